// File: doc/BRIEF.md
# Synchronous-Rectifier PWM Generator

This block drives the two switches of a synchronous boost stage: the main switch and the rectifier switch. A free-running period counter divides time into fixed frames of 2^CNT_W clocks. With the defaults of 9 bits and 512 clocks, one frame at a 100 MHz system clock lasts 5.12 us. The main-switch drive turns on at the start of every frame. It stays on for as many clocks as the duty value accepted for that frame.

The rectifier drive is the complement of the main drive, because the stage never leaves continuous conduction. Guard intervals of DEAD_CYC clocks surround it on both sides, so the two switches never conduct together. The duty command is clamped to a ceiling of 360 counts, about 70 %. It is taken in only at the frame boundary, so a command that changes mid-frame never cuts or stretches the pulse in progress. A one-clock frame strobe marks the first cycle of every frame for the blocks that produce the duty command.

All three outputs come straight from flip-flops. The reset is synchronous and active low.

Top module: `srpwm_gen`

## Requirements
- R1: While rst_n is low at a rising clock edge, all three outputs are 0 in the following cycle. The frame counter restarts, so the first cycle after rst_n returns high is a frame-start cycle.
- R2: frame_start is 1 for exactly one cycle in every frame of 512 clocks. That cycle is the first cycle of the frame (frame cycle index j = 0).
- R3: For the accepted duty D, main_drv is 1 in frame cycles j = 0 to D-1 and 0 for the rest of the frame. With D = 0, main_drv stays 0 for the whole frame.
- R4: A duty command above 360 is accepted as 360. Commands from 0 to 360 are accepted unchanged.
- R5: duty_cmd is sampled only at the rising edge that starts a frame-start cycle. Any change at other times has no effect on main_drv or rect_drv until the next frame.
- R6: rect_drv is 1 in frame cycles j = D+DEAD_CYC to 511-DEAD_CYC and 0 elsewhere (default DEAD_CYC = 4). It therefore rises DEAD_CYC cycles after main_drv falls, and falls DEAD_CYC cycles before main_drv next rises.
- R7: main_drv and rect_drv are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| duty_cmd | input | 9 | Requested on-time of the main switch, in clocks |
| main_drv | output | 1 | Main-switch gate command |
| rect_drv | output | 1 | Rectifier-switch gate command |
| frame_start | output | 1 | One-clock strobe in the first cycle of each frame |

## Verification
A wrong period count shows up within one frame. In that case frame_start and the main_drv rising edge drift away from the 512-clock grid the bench tracks from reset. A stale or mis-clamped duty register shows up in the first frame after the boundary that should have loaded it, as a main_drv pulse of the wrong length. A dead-time or compare fault shows up within the same frame, as a rect_drv edge that is shifted, or as overlap with main_drv. The duty pattern includes zero, one, the exact ceiling, values above the ceiling, and a contrasting command during each frame. A reset is also applied in the middle of a pulse.

// File: rtl/srpwm_pkg.sv
`timescale 1ns/1ps
// srpwm_pkg: shared defaults and the registered gate-drive bundle.
// Assumes all users take their widths from the top-level parameters.
package srpwm_pkg;
    localparam int unsigned DEF_CNT_W    = 9;
    localparam int unsigned DEF_DUTY_MAX = 360;
    localparam int unsigned DEF_DEAD_CYC = 4;

    typedef struct packed {
        logic frame;   // first cycle of the frame
        logic main;    // main switch on
        logic rect;    // rectifier switch on
    } gate_vec_t;
endpackage

// File: rtl/srpwm_frame_counter.sv
`timescale 1ns/1ps
// srpwm_frame_counter: free-running frame counter that wraps every 2^CNT_W clocks.
// Assumes a synchronous active-low reset. at_zero flags the count value 0.
module srpwm_frame_counter #(
    parameter int unsigned CNT_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [CNT_W-1:0] cnt,
    output logic             at_zero
);
    // count up every clock; wrap is natural overflow
    always_ff @(posedge clk) begin
        if (!rst_n) cnt <= '0;
        else        cnt <= cnt + 1'b1;
    end

    // frame boundary flag
    always_comb at_zero = (cnt == '0);
endmodule

// File: rtl/srpwm_duty_latch.sv
`timescale 1ns/1ps
// srpwm_duty_latch: clamps the command and holds it for one whole frame.
// Assumes at_zero is high exactly at the boundary count. The value seen in that
// boundary cycle is forwarded at once, so the new frame already uses it.
module srpwm_duty_latch #(
    parameter int unsigned CNT_W    = 9,
    parameter int unsigned DUTY_MAX = 360
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             at_zero,
    input  logic [CNT_W-1:0] duty_cmd,
    output logic [CNT_W-1:0] duty_eff
);
    localparam int unsigned FULL = (1 << CNT_W) - 1;

    logic [CNT_W-1:0] cmd_lim;
    logic [CNT_W-1:0] duty_q;

    // ceiling: the clamp exists only when the limit is below full scale
    generate
        if (DUTY_MAX < FULL) begin : g_clamp
            localparam logic [CNT_W-1:0] LIM = CNT_W'(DUTY_MAX);
            always_comb cmd_lim = (duty_cmd > LIM) ? LIM : duty_cmd;
        end else begin : g_pass
            always_comb cmd_lim = duty_cmd;
        end
    endgenerate

    // hold register, loaded only on the boundary count
    always_ff @(posedge clk) begin
        if (!rst_n)       duty_q <= '0;
        else if (at_zero) duty_q <= cmd_lim;
    end

    // bypass in the boundary cycle, held value otherwise
    always_comb duty_eff = at_zero ? cmd_lim : duty_q;
endmodule

// File: rtl/srpwm_gate_shaper.sv
`timescale 1ns/1ps
// srpwm_gate_shaper: turns count and duty into registered gate commands.
// Assumes duty_eff <= 2^CNT_W - 2*DEAD_CYC, so both guard intervals fit the frame.
// Outputs lag the count by one clock, so the frame cycle index equals the count
// seen at the previous edge.
module srpwm_gate_shaper
    import srpwm_pkg::*;
#(
    parameter int unsigned CNT_W    = 9,
    parameter int unsigned DEAD_CYC = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt,
    input  logic             at_zero,
    input  logic [CNT_W-1:0] duty_eff,
    output gate_vec_t        gates
);
    localparam logic [CNT_W:0] DEAD_X   = (CNT_W+1)'(DEAD_CYC);
    localparam logic [CNT_W:0] RECT_END = (CNT_W+1)'((1 << CNT_W) - DEAD_CYC);

    logic [CNT_W:0] cnt_x;
    logic [CNT_W:0] rect_beg;
    gate_vec_t      nxt;

    // next-cycle gate pattern from pure count comparisons
    always_comb begin
        cnt_x    = {1'b0, cnt};
        rect_beg = {1'b0, duty_eff} + DEAD_X;
        nxt.frame = at_zero;
        nxt.main  = (cnt < duty_eff);
        nxt.rect  = (cnt_x >= rect_beg) && (cnt_x < RECT_END);
    end

    // register the gates so the pins never glitch
    always_ff @(posedge clk) begin
        if (!rst_n) gates <= '0;
        else        gates <= nxt;
    end
endmodule

// File: rtl/srpwm_gen.sv
`timescale 1ns/1ps
// srpwm_gen: two-output PWM generator for a synchronous boost stage.
// Assumes a continuous-conduction stage: the rectifier drive is always the
// guarded complement of the main drive. Reset is synchronous, active low.
module srpwm_gen
    import srpwm_pkg::*;
#(
    parameter int unsigned CNT_W    = DEF_CNT_W,
    parameter int unsigned DUTY_MAX = DEF_DUTY_MAX,
    parameter int unsigned DEAD_CYC = DEF_DEAD_CYC
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] duty_cmd,
    output logic             main_drv,
    output logic             rect_drv,
    output logic             frame_start
);
    logic [CNT_W-1:0] cnt;
    logic             at_zero;
    logic [CNT_W-1:0] duty_eff;
    gate_vec_t        gates;

    srpwm_frame_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .cnt     (cnt),
        .at_zero (at_zero)
    );

    srpwm_duty_latch #(.CNT_W(CNT_W), .DUTY_MAX(DUTY_MAX)) u_duty (
        .clk      (clk),
        .rst_n    (rst_n),
        .at_zero  (at_zero),
        .duty_cmd (duty_cmd),
        .duty_eff (duty_eff)
    );

    srpwm_gate_shaper #(.CNT_W(CNT_W), .DEAD_CYC(DEAD_CYC)) u_shape (
        .clk      (clk),
        .rst_n    (rst_n),
        .cnt      (cnt),
        .at_zero  (at_zero),
        .duty_eff (duty_eff),
        .gates    (gates)
    );

    // map the registered bundle onto the pins
    always_comb begin
        main_drv    = gates.main;
        rect_drv    = gates.rect;
        frame_start = gates.frame;
    end
endmodule

// File: rtl/srpwm_gen_checker.sv
`timescale 1ns/1ps
// srpwm_gen_checker: port-level properties of srpwm_gen, attached with bind.
// Assumes DEAD_CYC and DUTY_MAX match the instance it observes.
module srpwm_gen_checker #(
    parameter int unsigned CNT_W    = 9,
    parameter int unsigned DUTY_MAX = 360,
    parameter int unsigned DEAD_CYC = 4
) (
    input logic clk,
    input logic rst_n,
    input logic main_drv,
    input logic rect_drv,
    input logic frame_start
);
    localparam int unsigned SW = $clog2(DEAD_CYC + 1) + 1;
    localparam logic [SW-1:0] CAP = SW'(DEAD_CYC);

    logic [SW-1:0]  since_main;  // prior consecutive cycles with main low
    logic [SW-1:0]  since_rect;  // prior consecutive cycles with rect low
    logic [CNT_W:0] run_main;    // prior consecutive cycles with main high

    // quiet-cycle counters, saturating at the dead time
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_main <= CAP;
            since_rect <= CAP;
            run_main   <= '0;
        end else begin
            since_main <= main_drv ? '0 : ((since_main < CAP) ? since_main + 1'b1 : since_main);
            since_rect <= rect_drv ? '0 : ((since_rect < CAP) ? since_rect + 1'b1 : since_rect);
            run_main   <= main_drv ? run_main + 1'b1 : '0;
        end
    end

    // R1: reset silences every output in the next cycle
    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (!main_drv && !rect_drv && !frame_start));

    // R2: the frame strobe lasts a single cycle
    a_r2_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> !frame_start);

    // R3: the main drive only turns on in a frame-start cycle
    a_r3_rise_on_frame: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(main_drv) |-> frame_start);

    // R4: the main pulse never reaches the duty ceiling in length
    a_r4_ceiling: assert property (@(posedge clk) disable iff (!rst_n)
        main_drv |-> (run_main < (CNT_W+1)'(DUTY_MAX)));

    // R6: the rectifier waits a full dead time after main falls
    a_r6_gap_after_main: assert property (@(posedge clk) disable iff (!rst_n)
        rect_drv |-> (since_main >= CAP));

    // R6: main waits a full dead time after the rectifier falls
    a_r6_gap_before_main: assert property (@(posedge clk) disable iff (!rst_n)
        main_drv |-> (since_rect >= CAP));

    // R7: no shoot-through
    a_r7_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(main_drv && rect_drv));
endmodule

bind srpwm_gen srpwm_gen_checker #(
    .CNT_W(CNT_W), .DUTY_MAX(DUTY_MAX), .DEAD_CYC(DEAD_CYC)
) u_srpwm_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .main_drv    (main_drv),
    .rect_drv    (rect_drv),
    .frame_start (frame_start)
);

// File: tb/srpwm_gen_bench.sv
`timescale 1ns/1ps
// srpwm_gen_bench: scoreboard bench. The driver pushes one expected item per
// cycle; the monitor pops one item per cycle and compares it with the pins.
module srpwm_gen_bench;
    localparam int FRAME = 512;
    localparam int LIMIT = 360;
    localparam int DEAD  = 4;

    typedef struct packed {
        logic       fs;
        logic       mn;
        logic       rc;
        logic [3:0] req;   // requirement tag number for main-drive mismatches
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [8:0] duty_cmd = '0;
    logic       main_drv, rect_drv, frame_start;

    exp_t q[$];
    int   n_chk = 0;
    int   n_fail = 0;
    bit   done = 1'b0;

    srpwm_gen u_srpwm_gen (
        .clk(clk), .rst_n(rst_n), .duty_cmd(duty_cmd),
        .main_drv(main_drv), .rect_drv(rect_drv), .frame_start(frame_start)
    );

    always #10 clk = ~clk;   // 50 MHz

    function automatic string tag(input logic [3:0] r);
        case (r)
            4'd1:    return "R1";
            4'd2:    return "R2";
            4'd3:    return "R3";
            4'd4:    return "R4";
            4'd5:    return "R5";
            4'd6:    return "R6";
            default: return "R7";
        endcase
    endfunction

    // push the expected reset-state items; reset rows are tagged R1
    task automatic hold_reset(input int cycles);
        rst_n = 1'b0;
        for (int i = 0; i < cycles; i++) q.push_back('{1'b0, 1'b0, 1'b0, 4'd1});
        repeat (cycles) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // drive one frame: cmd before the boundary, junk once it has been taken
    task automatic run_frame(input int cmd, input int junk, input int ncyc, input logic [3:0] req);
        int d;
        d = (cmd > LIMIT) ? LIMIT : cmd;          // R4 ceiling
        duty_cmd = 9'(cmd);
        for (int j = 0; j < ncyc; j++) begin
            q.push_back('{(j == 0), (j < d),                       // R2, R3
                          (j >= d + DEAD) && (j < FRAME - DEAD),   // R6
                          req});
        end
        @(negedge clk);
        duty_cmd = 9'(junk);                       // R5: must be ignored
        repeat (ncyc - 1) @(negedge clk);
    endtask

    // monitor: compare away from the active edge
    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                n_chk++;
                if (frame_start !== e.fs) begin
                    n_fail++;
                    $display("FAIL %s frame_start actual=%b expected=%b",
                             (e.req == 4'd1) ? "R1" : "R2", frame_start, e.fs);
                end else if (main_drv !== e.mn) begin
                    n_fail++;
                    $display("FAIL %s main_drv actual=%b expected=%b", tag(e.req), main_drv, e.mn);
                end else if (rect_drv !== e.rc) begin
                    n_fail++;
                    $display("FAIL %s rect_drv actual=%b expected=%b",
                             (e.req == 4'd1) ? "R1" : "R6", rect_drv, e.rc);
                end
                n_chk++;   // R7 shoot-through check on every cycle
                if (main_drv === 1'b1 && rect_drv === 1'b1) begin
                    n_fail++;
                    $display("FAIL R7 overlap actual=11 expected=not both high");
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL R2 watchdog: queue left=%0d expected=0", q.size());
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    // driver sequence
    initial begin
        @(posedge clk);
        @(negedge clk);
        duty_cmd = 9'd200;
        hold_reset(4);                    // R1 reset state
        run_frame(100, 300, FRAME, 4'd3); // R3 mid duty
        run_frame(0,   200, FRAME, 4'd3); // R3 zero duty
        run_frame(360, 0,   FRAME, 4'd4); // R4 exact ceiling
        run_frame(400, 50,  FRAME, 4'd4); // R4 clamped
        run_frame(511, 511, FRAME, 4'd4); // R4 full-scale command
        run_frame(1,   359, FRAME, 4'd5); // R5 one-clock pulse, junk ignored
        run_frame(256, 10,  150,   4'd3); // cut short by reset mid-pulse
        hold_reset(3);                    // R1 restart
        run_frame(359, 0,   FRAME, 4'd5); // R5 new frame after restart
        run_frame(200, 100, FRAME, 4'd3); // R3
        @(posedge clk);
        #6;
        if (q.size() != 0) begin
            n_fail++;
            $display("FAIL R2 leftover items actual=%0d expected=0", q.size());
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule